// File: doc/BRIEF.md
# Write-protected BCD calendar clock

This block is a calendar clock that sits on a simple 32-bit register bus with an address, write data, a write strobe and combinational read data. A free-running tick enable at the oscillator rate is divided down to one step per second. Each step advances seconds, minutes, hours, day of month, month, a two-digit year (century taken as 2000) and a weekday, all held as packed BCD with the tens digit in the upper nibble. February has 29 days in years whose two digits are divisible by four.

Every register write is refused until software writes the first key to one kick register and then the second key to the other. Writing any other value to either kick register closes the gate again. A run bit in the control register starts and freezes counting. A busy bit in the status register rises a fixed number of ticks before each step, so software can wait for it to clear before it changes a time field.

Top module: `rtc_bcd_top`

## Requirements
- R1: After reset the time fields read seconds, minutes, hours 00, day 01, month 01, year 00, weekday 0; control, status, oscillator select and configuration read 0; writes are locked.
- R2: Byte offsets: seconds 0x00, minutes 0x04, hours 0x08, day 0x0C, month 0x10, year 0x14, weekday 0x18, control 0x40 (bit 0 run), status 0x44 (bit 0 busy, read-only), oscillator select 0x54 (bit 6), revision 0x74 (read-only, REV_ID), configuration 0x78 (bit 0). Stored widths are 7 bits for seconds and minutes, 6 for hours and day, 5 for month, 8 for year, 3 for weekday; all other bits read 0, and the kick registers read 0.
- R3: Writes open only when 0x83E70B13 is written to the kick register at 0x6C and, after that, 0x95A4F1E0 to the one at 0x70; the second key alone, or before the first, leaves writes locked.
- R4: Writing any other value to either kick register locks writes again, including between the two keys.
- R5: While locked, a write to any register other than the two kick registers leaves it unchanged.
- R6: While running, the seconds field advances once per TICKS_PER_SEC cycles in which tick_en is high; cycles with tick_en low are not counted.
- R7: Clearing the run bit freezes both the time fields and the tick count, which resumes from where it stopped when run is set again.
- R8: Seconds and minutes roll from 59 to 00 and hours from 23 to 00 in BCD, each rollover carrying one into the next field.
- R9: The day rolls to 01 after the last day of the month (30 for months 04, 06, 09, 11; 28 or 29 for 02 by leap year; 31 otherwise), carrying into the month; month 12 rolls to 01 carrying into the year; year 99 rolls to 00.
- R10: The weekday advances with each change of day, counting 0 to 6 and wrapping to 0.
- R11: Status bit 0 is 1 while running during the last BUSY_TICKS tick counts before each step, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Oscillator-rate tick enable |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |

## Verification
The bench sweeps every second, minute and hour value through one step and every month of four years (a plain year, a leap year, year 00 and year 99) at its last day and the day before, so a design with a wrong month length, a missing leap day, a binary instead of BCD increment or a lost carry shows a wrong field. It drives the keys in the wrong order, one key alone and a bad key between the two keys; a gate that opened on either key alone would let a protected write through. It stops the clock mid-second and counts the remaining ticks after restart, which catches a divider that resets or keeps counting while stopped, and it samples the busy bit on the tick counts on both sides of its window.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NFIELD       = 7;
    localparam int FIELD_STRIDE = 4;
    localparam int F_SEC = 0;
    localparam int F_MIN = 1;
    localparam int F_HR  = 2;
    localparam int F_DAY = 3;
    localparam int F_MON = 4;
    localparam int F_YR  = 5;
    localparam int F_WK  = 6;

    localparam logic [7:0] OFS_CTRL = 8'h40;
    localparam logic [7:0] OFS_STAT = 8'h44;
    localparam logic [7:0] OFS_OSC  = 8'h54;
    localparam logic [7:0] OFS_KEYA = 8'h6C;
    localparam logic [7:0] OFS_KEYB = 8'h70;
    localparam logic [7:0] OFS_REV  = 8'h74;
    localparam logic [7:0] OFS_CFG  = 8'h78;
    localparam int         OSC_BIT  = 6;

    localparam logic [31:0] KEY_A = 32'h83E7_0B13;
    localparam logic [31:0] KEY_B = 32'h95A4_F1E0;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hr;
        logic [5:0] day;
        logic [4:0] mon;
        logic [7:0] yr;
        logic [2:0] wk;
    } cal_t;

    typedef enum logic [1:0] {LK_SHUT, LK_HALF, LK_OPEN} lock_e;

    // Add one to a two-digit packed BCD value (no wrap handling).
    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic [6:0] bcd_bin(input logic [7:0] v);
        logic [6:0] t;
        t = {3'b000, v[7:4]};
        return (t << 3) + (t << 1) + {3'b000, v[3:0]};
    endfunction

    // Last day of a month in BCD, given BCD month and two-digit BCD year.
    function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
        logic [6:0] y;
        logic [5:0] r;
        y = bcd_bin(yr);
        case (mon)
            5'h02:                      r = (y[1:0] == 2'b00) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
            default:                    r = 6'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int BUSY_TICKS    = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick_en,
    output logic sec_step,
    output logic busy
);
    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST  = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] BSTART = CW'(TICKS_PER_SEC - BUSY_TICKS);

    logic [CW-1:0] cnt;

    assign sec_step = run && tick_en && (cnt == LAST);
    assign busy     = run && (cnt >= BSTART);

    always_ff @(posedge clk) begin
        if (rst)                  cnt <= '0;
        else if (run && tick_en)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // R11
    generate
        if (BUSY_TICKS > 0) begin : g_busy_chk
            busy_before_step_chk: assert property (@(posedge clk) disable iff (rst)
                sec_step |-> busy);
        end
    endgenerate

    // R7
    frozen_count_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt));

endmodule

// File: rtl/rtc_unlock.sv
module rtc_unlock
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ka_wr,
    input  logic        kb_wr,
    input  logic [31:0] wdata,
    output logic        unlocked
);
    lock_e st;

    always_ff @(posedge clk) begin
        if (rst) st <= LK_SHUT;
        else if (ka_wr) begin
            if (wdata != KEY_A)      st <= LK_SHUT;
            else if (st == LK_SHUT)  st <= LK_HALF;
        end else if (kb_wr) begin
            if (wdata != KEY_B)      st <= LK_SHUT;
            else if (st == LK_HALF)  st <= LK_OPEN;
        end
    end

    assign unlocked = (st == LK_OPEN);

    // R3
    open_needs_second_key_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(kb_wr && wdata == KEY_B));

    // R4
    bad_key_locks_chk: assert property (@(posedge clk) disable iff (rst)
        ((ka_wr && wdata != KEY_A) || (kb_wr && wdata != KEY_B)) |=> !unlocked);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [NFIELD-1:0] wr_field,
    input  logic [7:0]        wdata,
    output cal_t              cur
);
    cal_t nxt;
    logic c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        nxt   = cur;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;
        if (step) begin
            if ({1'b0, cur.sec} >= 8'h59) begin nxt.sec = '0; c_min = 1'b1; end
            else nxt.sec = 7'(bcd_next({1'b0, cur.sec}));
            if (c_min) begin
                if ({1'b0, cur.min} >= 8'h59) begin nxt.min = '0; c_hr = 1'b1; end
                else nxt.min = 7'(bcd_next({1'b0, cur.min}));
            end
            if (c_hr) begin
                if ({2'b00, cur.hr} >= 8'h23) begin nxt.hr = '0; c_day = 1'b1; end
                else nxt.hr = 6'(bcd_next({2'b00, cur.hr}));
            end
            if (c_day) begin
                if (cur.day >= last_day(cur.mon, cur.yr)) begin nxt.day = 6'h01; c_mon = 1'b1; end
                else nxt.day = 6'(bcd_next({2'b00, cur.day}));
                nxt.wk = (cur.wk >= 3'd6) ? 3'd0 : cur.wk + 3'd1;
            end
            if (c_mon) begin
                if (cur.mon >= 5'h12) begin nxt.mon = 5'h01; c_yr = 1'b1; end
                else nxt.mon = 5'(bcd_next({3'b000, cur.mon}));
            end
            if (c_yr) nxt.yr = (cur.yr >= 8'h99) ? 8'h00 : bcd_next(cur.yr);
        end
        // A bus write to a field takes precedence over the step for that field.
        if (wr_field[F_SEC]) nxt.sec = wdata[6:0];
        if (wr_field[F_MIN]) nxt.min = wdata[6:0];
        if (wr_field[F_HR])  nxt.hr  = wdata[5:0];
        if (wr_field[F_DAY]) nxt.day = wdata[5:0];
        if (wr_field[F_MON]) nxt.mon = wdata[4:0];
        if (wr_field[F_YR])  nxt.yr  = wdata[7:0];
        if (wr_field[F_WK])  nxt.wk  = wdata[2:0];
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '{sec: '0, min: '0, hr: '0, day: 6'h01, mon: 5'h01, yr: '0, wk: '0};
        else     cur <= nxt;
    end

    // R8
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_field[F_SEC] && cur.sec == 7'h59) |=> (cur.sec == 7'h00));

    // R9
    year_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (c_yr && !wr_field[F_YR] && cur.yr == 8'h99) |=> (cur.yr == 8'h00));

    // R10
    weekday_range_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_field[F_WK] && cur.wk <= 3'd6) |=> (cur.wk <= 3'd6));

endmodule

// File: rtl/rtc_bcd_top.sv
module rtc_bcd_top
    import rtc_pkg::*;
#(
    parameter int          TICKS_PER_SEC = 32768,
    parameter int          BUSY_TICKS    = 16,
    parameter logic [31:0] REV_ID        = 32'h0000_0102
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    logic              unlocked, wr_ok, run, osc_sel, cfg_bit;
    logic              sec_step, busy;
    logic [NFIELD-1:0] wr_field;
    cal_t              cal;

    assign wr_ok = bus_wr && unlocked;

    rtc_unlock u_unlock (
        .clk      (clk),
        .rst      (rst),
        .ka_wr    (bus_wr && bus_addr == OFS_KEYA),
        .kb_wr    (bus_wr && bus_addr == OFS_KEYB),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    rtc_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC), .BUSY_TICKS(BUSY_TICKS)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick_en  (tick_en),
        .sec_step (sec_step),
        .busy     (busy)
    );

    generate
        for (genvar gi = 0; gi < NFIELD; gi++) begin : g_wsel
            assign wr_field[gi] = wr_ok && (bus_addr == 8'(gi * FIELD_STRIDE));
        end
    endgenerate

    rtc_calendar u_cal (
        .clk      (clk),
        .rst      (rst),
        .step     (sec_step),
        .wr_field (wr_field),
        .wdata    (bus_wdata[7:0]),
        .cur      (cal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            osc_sel <= 1'b0;
            cfg_bit <= 1'b0;
        end else if (wr_ok) begin
            if (bus_addr == OFS_CTRL) run     <= bus_wdata[0];
            if (bus_addr == OFS_OSC)  osc_sel <= bus_wdata[OSC_BIT];
            if (bus_addr == OFS_CFG)  cfg_bit <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            8'h00:    bus_rdata = {25'b0, cal.sec};
            8'h04:    bus_rdata = {25'b0, cal.min};
            8'h08:    bus_rdata = {26'b0, cal.hr};
            8'h0C:    bus_rdata = {26'b0, cal.day};
            8'h10:    bus_rdata = {27'b0, cal.mon};
            8'h14:    bus_rdata = {24'b0, cal.yr};
            8'h18:    bus_rdata = {29'b0, cal.wk};
            OFS_CTRL: bus_rdata = {31'b0, run};
            OFS_STAT: bus_rdata = {31'b0, busy};
            OFS_OSC:  bus_rdata = 32'(osc_sel) << OSC_BIT;
            OFS_REV:  bus_rdata = REV_ID;
            OFS_CFG:  bus_rdata = {31'b0, cfg_bit};
            default:  bus_rdata = '0;
        endcase
    end

    // R5
    locked_sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h00 && !unlocked && !sec_step) |=> $stable(cal.sec));

    // R5
    locked_run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CTRL && !unlocked) |=> $stable(run));

endmodule

// File: tb/tb_rtc_bcd_top.sv
module tb_rtc_bcd_top;
    localparam int TPS  = 8;
    localparam int BUSY = 3;
    localparam logic [31:0] REV = 32'h0000_0102;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad = 0;
    int pc = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rtc_bcd_top #(.TICKS_PER_SEC(TPS), .BUSY_TICKS(BUSY), .REV_ID(REV)) dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !finished) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] to_bcd(input int n);
        return 32'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int mlen(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        total = total + 1;
        if (bus_rdata !== exp) begin
            bad = bad + 1;
            $display("FAIL %s addr=%h: act=%h exp=%h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic step_one();
        ticks(TPS - pc);
        pc = 0;
    endtask

    task automatic unlock();
        wr(8'h6C, 32'h83E7_0B13);
        wr(8'h70, 32'h95A4_F1E0);
    endtask

    task automatic set_all(input int s, input int mi, input int h, input int d,
                           input int mo, input int y, input int w);
        wr(8'h00, to_bcd(s));  wr(8'h04, to_bcd(mi)); wr(8'h08, to_bcd(h));
        wr(8'h0C, to_bcd(d));  wr(8'h10, to_bcd(mo)); wr(8'h14, to_bcd(y));
        wr(8'h18, 32'(w));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", 8'h00, 0); chk("R1", 8'h04, 0); chk("R1", 8'h08, 0);
        chk("R1", 8'h0C, 32'h01); chk("R1", 8'h10, 32'h01); chk("R1", 8'h14, 0);
        chk("R1", 8'h18, 0); chk("R1", 8'h40, 0); chk("R1", 8'h44, 0);
        chk("R1", 8'h54, 0); chk("R1", 8'h78, 0); chk("R2", 8'h74, REV);

        // R5 locked after reset
        wr(8'h00, 32'h22); chk("R5", 8'h00, 0);
        wr(8'h40, 32'h1);  chk("R5", 8'h40, 0);
        wr(8'h78, 32'h1);  chk("R5", 8'h78, 0);

        // R3 second key alone, then wrong order
        wr(8'h70, 32'h95A4_F1E0); wr(8'h00, 32'h11); chk("R3", 8'h00, 0);
        wr(8'h6C, 32'h83E7_0B13); wr(8'h00, 32'h11); chk("R3", 8'h00, 0);
        wr(8'h70, 32'h95A4_F1E0); wr(8'h00, 32'h45); chk("R3", 8'h00, 32'h45);

        // R2 masks, read-only and key readback
        wr(8'h00, 32'hFFFF_FFFF); chk("R2", 8'h00, 32'h7F);
        wr(8'h04, 32'hFFFF_FFFF); chk("R2", 8'h04, 32'h7F);
        wr(8'h08, 32'hFFFF_FFFF); chk("R2", 8'h08, 32'h3F);
        wr(8'h0C, 32'hFFFF_FFFF); chk("R2", 8'h0C, 32'h3F);
        wr(8'h10, 32'hFFFF_FFFF); chk("R2", 8'h10, 32'h1F);
        wr(8'h14, 32'hFFFF_FFFF); chk("R2", 8'h14, 32'hFF);
        wr(8'h18, 32'hFFFF_FFFF); chk("R2", 8'h18, 32'h07);
        wr(8'h54, 32'hFFFF_FFFF); chk("R2", 8'h54, 32'h40);
        wr(8'h78, 32'hFFFF_FFFF); chk("R2", 8'h78, 32'h01);
        wr(8'h74, 32'h0);         chk("R2", 8'h74, REV);
        wr(8'h44, 32'hFFFF_FFFF); chk("R2", 8'h44, 0);
        chk("R2", 8'h6C, 0); chk("R2", 8'h70, 0);
        wr(8'h54, 32'h0); chk("R2", 8'h54, 0);
        wr(8'h78, 32'h0); chk("R2", 8'h78, 0);
        wr(8'h00, 32'h00);

        // R4 relock by bad value; bad key between the two keys
        wr(8'h6C, 32'h1111_1111); wr(8'h00, 32'h33); chk("R4", 8'h00, 0);
        unlock(); wr(8'h70, 32'h1111_1111); wr(8'h00, 32'h33); chk("R4", 8'h00, 0);
        wr(8'h6C, 32'h83E7_0B13); wr(8'h70, 32'h0000_0001);
        wr(8'h70, 32'h95A4_F1E0); wr(8'h00, 32'h33); chk("R4", 8'h00, 0);
        unlock(); wr(8'h00, 32'h33); chk("R3", 8'h00, 32'h33);

        // R6 / R11 start running from a clean time
        set_all(0, 0, 0, 1, 1, 0, 0);
        wr(8'h40, 32'h1); pc = 0;
        ticks(4); pc = 4; chk("R11", 8'h44, 0); chk("R6", 8'h00, 0);
        ticks(1); pc = 5; chk("R11", 8'h44, 1);
        ticks(2); pc = 7; chk("R11", 8'h44, 1); chk("R6", 8'h00, 0);
        ticks(1); pc = 0; chk("R6", 8'h00, 1); chk("R11", 8'h44, 0);
        repeat (30) @(negedge clk);
        chk("R6", 8'h00, 1);

        // R7 stop mid-second
        ticks(3); pc = 3;
        wr(8'h40, 32'h0);
        ticks(20);
        chk("R7", 8'h00, 1); chk("R7", 8'h44, 0);
        wr(8'h40, 32'h1);
        ticks(4); chk("R7", 8'h00, 1);
        ticks(1); pc = 0; chk("R7", 8'h00, 2);

        // R8 seconds sweep
        for (int s = 0; s < 60; s++) begin
            set_all(s, 10, 5, 3, 3, 15, 2);
            step_one();
            chk("R8", 8'h00, to_bcd((s + 1) % 60));
            chk("R8", 8'h04, to_bcd(s == 59 ? 11 : 10));
        end
        // R8 minutes sweep
        for (int m = 0; m < 60; m++) begin
            set_all(59, m, 5, 3, 3, 15, 2);
            step_one();
            chk("R8", 8'h04, to_bcd((m + 1) % 60));
            chk("R8", 8'h08, to_bcd(m == 59 ? 6 : 5));
        end
        // R8 hours sweep
        for (int h = 0; h < 24; h++) begin
            set_all(59, 59, h, 3, 3, 15, 2);
            step_one();
            chk("R8", 8'h08, to_bcd((h + 1) % 24));
            chk("R8", 8'h0C, to_bcd(h == 23 ? 4 : 3));
            chk("R10", 8'h18, h == 23 ? 3 : 2);
        end

        // R9 / R10 month-end sweep over four years
        for (int yi = 0; yi < 4; yi++) begin
            int y;
            y = (yi == 0) ? 23 : (yi == 1) ? 24 : (yi == 2) ? 0 : 99;
            for (int mo = 1; mo <= 12; mo++) begin
                int last, w;
                last = mlen(mo, y);
                w = mo % 7;
                set_all(59, 59, 23, last - 1, mo, y, w);
                step_one();
                chk("R9", 8'h0C, to_bcd(last));
                chk("R9", 8'h10, to_bcd(mo));
                chk("R10", 8'h18, 32'((w + 1) % 7));
                set_all(59, 59, 23, last, mo, y, w);
                step_one();
                chk("R9", 8'h0C, 32'h01);
                chk("R9", 8'h10, to_bcd(mo == 12 ? 1 : mo + 1));
                chk("R9", 8'h14, to_bcd(mo == 12 ? (y + 1) % 100 : y));
                chk("R8", 8'h08, 0);
                chk("R10", 8'h18, 32'((w + 1) % 7));
            end
        end

        // R5 lock again; control write must not stop the clock
        wr(8'h70, 32'h1111_1111);
        wr(8'h40, 32'h0); chk("R5", 8'h40, 1);
        wr(8'h14, 32'h42); chk("R5", 8'h14, to_bcd(0));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule